// File: doc/BRIEF.md
# Dual-Image Transactional Line Cache

This block is a small, fully associative cache that holds every line touched by the one transaction currently open on a processor. When a transaction reads or writes a line for the first time, the cache claims two slots for it. One slot keeps the value the line had before the transaction began and is marked to survive an abort. The other keeps the value the transaction is building and is marked to survive a commit. A line that is only read still takes both slots. Because both images already exist, commit and abort only relabel slots, and neither copies data. Commit also writes the new values through to a small backing word store, which stands in for the rest of the memory system. A transaction opens implicitly on its first load or store. It closes on a commit or an abort operation.

The processor side uses a request/response interface. `req_ready` is high whenever reset is released, so requests are never stalled. Every accepted request gets exactly one `rsp_valid` pulse in the following cycle. There is no response back-pressure, so the processor must take the response in that cycle. A snoop port lets another agent ask about an address. The block answers in the same cycle with `snp_nack` when the request would break the isolation of the open transaction. When the processor's own outgoing request is refused by another agent, `own_nack` tells the block, and the block aborts the transaction. The abort is recorded as pending until the processor ends the transaction. A validate operation reports whether such an abort is pending.

Top module: `tc_txcache`

## Requirements
- R1: `req_ready` is 0 while `rst_n` is low and 1 otherwise. Each accepted request (`req_valid && req_ready`) produces `rsp_valid`=1 exactly one cycle later. In any other cycle `rsp_valid` is 0.
- R2: Operation codes on `req_op` are: 0 load, 1 store, 2 commit, 3 abort, 4 validate. A load of a line not yet in the transaction returns the backing word. After reset, backing word `a` holds `(37*a + 5) mod 2^DW`. The load opens the transaction if none is open.
- R3: A store inside the transaction returns `rsp_ok`=1. Later loads of that address in the same transaction return the stored value. Loads of other addresses are unaffected.
- R4: Each line in a transaction uses two slots: a before image and an after image. The transaction can therefore hold NSLOT/2 distinct lines, and all of them are accepted.
- R5: A commit with no pending abort returns `rsp_ok`=1. Values stored in the transaction become the contents seen by later transactions. The transaction closes.
- R6: An abort returns `rsp_ok`=1, discards every store of the transaction, releases its lines and closes it.
- R7: `snp_nack` is 1 exactly when `snp_valid` is 1 and `snp_addr` is a line held by the open transaction and either `snp_write`=1 or the transaction has stored to that line. A snoop read of a line the transaction has only read is not refused.
- R8: `own_nack`=1 while a transaction is open and has no pending abort aborts it. Its stores are discarded and its lines are released, so snoops are no longer refused. The abort stays pending, including for a request in the same cycle, until a commit or an abort closes the transaction.
- R9: A load or store that needs a new line while NSLOT/2 lines are held returns `rsp_ok`=0 and aborts the transaction as in R8.
- R10: Validate returns `rsp_ok`=1 exactly when no abort is pending, and changes nothing. While an abort is pending, loads and stores return `rsp_ok`=0. A commit returns `rsp_ok`=0 and closes the transaction.
- R11: `rsp_data` is 0 except on a successful load. Operation codes 5 to 7 return `rsp_ok`=0 and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted (high outside reset) |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | AW | Line address |
| req_wdata | input | DW | Store value |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_ok | output | 1 | Operation succeeded |
| rsp_data | output | DW | Load result, else 0 |
| own_nack | input | 1 | Processor's outgoing request was refused |
| snp_valid | input | 1 | Snoop request present |
| snp_write | input | 1 | Snoop wants write ownership |
| snp_addr | input | AW | Snooped line address |
| snp_nack | output | 1 | Snoop refused (same cycle) |

## Verification
The assertions check the structural invariants on every cycle. They confirm that a response follows each accepted request and nothing else, that before and after images stay equal in number, and that no more than NSLOT/2 after images exist. They also confirm that a refusal never appears without a snoop and that no after image survives a commit, an abort or an own-request refusal. Data correctness needs the bench's scenarios. These cover the values returned by loads, stores becoming visible or vanishing across commit and abort, the exact refusal rule for read and write snoops, the pending-abort behaviour of validate and commit, and the capacity edge at the fifth line. A long pseudo-random run over a narrow address range compares every response and snoop answer against an arithmetic model.

// File: rtl/tc_pkg.sv
package tc_pkg;
  // Label of a slot; the before/after pairing is carried by these labels.
  typedef enum logic [1:0] {
    SL_INV  = 2'd0,
    SL_NORM = 2'd1,
    SL_XCOM = 2'd2,
    SL_XABT = 2'd3
  } slot_st_e;

  typedef enum logic {
    COH_S = 1'b0,
    COH_M = 1'b1
  } coh_e;

  typedef enum logic [2:0] {
    OP_LOAD     = 3'd0,
    OP_STORE    = 3'd1,
    OP_COMMIT   = 3'd2,
    OP_ABORT    = 3'd3,
    OP_VALIDATE = 3'd4
  } tx_op_e;
endpackage

// File: rtl/tc_lookup.sv
module tc_lookup import tc_pkg::*; #(
  parameter int NSLOT = 8,
  parameter int AW    = 4,
  localparam int IW   = $clog2(NSLOT),
  localparam int CW   = $clog2(NSLOT + 1)
) (
  input  slot_st_e          st   [NSLOT],
  input  logic [AW-1:0]     tag  [NSLOT],
  input  logic [AW-1:0]     key,
  output logic              com_hit,
  output logic [IW-1:0]     com_idx,
  output logic [IW-1:0]     abt_idx,
  output logic [CW-1:0]     free_cnt,
  output logic [IW-1:0]     free_lo,
  output logic [IW-1:0]     free_hi
);
  always_comb begin
    com_hit  = 1'b0;
    com_idx  = '0;
    abt_idx  = '0;
    free_cnt = '0;
    free_lo  = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (st[i] == SL_XCOM && tag[i] == key) begin
        com_hit = 1'b1;
        com_idx = IW'(i);
      end
      if (st[i] == SL_XABT && tag[i] == key) abt_idx = IW'(i);
      if (st[i] == SL_INV || st[i] == SL_NORM) begin
        free_lo  = IW'(i);
        free_cnt = free_cnt + CW'(1);
      end
    end
  end

  always_comb begin
    free_hi = '0;
    for (int i = 0; i < NSLOT; i++)
      if (st[i] == SL_INV || st[i] == SL_NORM) free_hi = IW'(i);
  end
endmodule

// File: rtl/tc_conflict.sv
module tc_conflict import tc_pkg::*; #(
  parameter int NSLOT = 8,
  parameter int AW    = 4
) (
  input  slot_st_e      st  [NSLOT],
  input  coh_e          coh [NSLOT],
  input  logic [AW-1:0] tag [NSLOT],
  input  logic          snp_valid,
  input  logic          snp_write,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_nack
);
  logic [NSLOT-1:0] clash;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign clash[i] = (st[i] == SL_XCOM) && (tag[i] == snp_addr) &&
                      (snp_write || coh[i] == COH_M);
  end

  assign snp_nack = snp_valid && (|clash);
endmodule

// File: rtl/tc_backing.sv
module tc_backing #(
  parameter int NSLOT = 8,
  parameter int AW    = 4,
  parameter int DW    = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOT-1:0]  wr_slot,
  input  logic [AW-1:0]     tag [NSLOT],
  input  logic [DW-1:0]     val [NSLOT],
  input  logic [AW-1:0]     raddr,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] words [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic          we;
    logic [DW-1:0] wd;
    logic [DW-1:0] word_q;

    always_comb begin
      we = 1'b0;
      wd = '0;
      for (int i = 0; i < NSLOT; i++)
        if (wr_slot[i] && tag[i] == AW'(w)) begin
          we = 1'b1;
          wd = val[i];
        end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)  word_q <= DW'(37 * w + 5);
      else if (we) word_q <= wd;
    end

    assign words[w] = word_q;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/tc_txcache.sv
module tc_txcache import tc_pkg::*; #(
  parameter int NSLOT = 8,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic [DW-1:0] rsp_data,
  input  logic          own_nack,
  input  logic          snp_valid,
  input  logic          snp_write,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_nack
);
  localparam int IW = $clog2(NSLOT);
  localparam int CW = $clog2(NSLOT + 1);

  slot_st_e      st_q  [NSLOT];
  coh_e          coh_q [NSLOT];
  logic [AW-1:0] tag_q [NSLOT];
  logic [DW-1:0] dat_q [NSLOT];
  logic          tx_active_q, pend_q;

  logic          com_hit;
  logic [IW-1:0] com_idx, abt_idx, free_lo, free_hi;
  logic [CW-1:0] free_cnt;
  logic [DW-1:0] mem_rdata;
  logic [NSLOT-1:0] wr_slot;

  tc_lookup #(.NSLOT(NSLOT), .AW(AW)) u_lookup (
    .st(st_q), .tag(tag_q), .key(req_addr),
    .com_hit(com_hit), .com_idx(com_idx), .abt_idx(abt_idx),
    .free_cnt(free_cnt), .free_lo(free_lo), .free_hi(free_hi));

  tc_conflict #(.NSLOT(NSLOT), .AW(AW)) u_conflict (
    .st(st_q), .coh(coh_q), .tag(tag_q),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
    .snp_nack(snp_nack));

  tc_backing #(.NSLOT(NSLOT), .AW(AW), .DW(DW)) u_backing (
    .clk(clk), .rst_n(rst_n), .wr_slot(wr_slot), .tag(tag_q), .val(dat_q),
    .raddr(req_addr), .rdata(mem_rdata));

  assign req_ready = rst_n;

  // Request decode
  logic acc, is_ld, is_st, is_cm, is_ab, is_va;
  assign acc   = req_valid && req_ready;
  assign is_ld = acc && req_op == OP_LOAD;
  assign is_st = acc && req_op == OP_STORE;
  assign is_cm = acc && req_op == OP_COMMIT;
  assign is_ab = acc && req_op == OP_ABORT;
  assign is_va = acc && req_op == OP_VALIDATE;

  logic nack_roll, eff_pend, mem_acc, tx_hit, need_alloc, do_alloc, cap_fail;
  logic do_commit, do_roll;
  assign nack_roll  = own_nack && tx_active_q && !pend_q;
  assign eff_pend   = pend_q || nack_roll;
  assign mem_acc    = (is_ld || is_st) && !eff_pend;
  assign tx_hit     = mem_acc && com_hit;
  assign need_alloc = mem_acc && !com_hit;
  assign do_alloc   = need_alloc && (free_cnt >= CW'(2));
  assign cap_fail   = need_alloc && !(free_cnt >= CW'(2));
  assign do_commit  = is_cm && !eff_pend;
  assign do_roll    = nack_roll || cap_fail || is_ab || (is_cm && eff_pend);

  for (genvar i = 0; i < NSLOT; i++) begin : g_wr
    assign wr_slot[i] = do_commit && st_q[i] == SL_XCOM;
  end

  logic          ok_d;
  logic [DW-1:0] data_d;
  always_comb begin
    ok_d   = 1'b0;
    data_d = '0;
    if (is_ld || is_st) ok_d = tx_hit || do_alloc;
    else if (is_cm || is_va) ok_d = !eff_pend;
    else if (is_ab) ok_d = 1'b1;
    if (is_ld && tx_hit)   data_d = dat_q[com_idx];
    if (is_ld && do_alloc) data_d = mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc;
      rsp_ok    <= ok_d;
      rsp_data  <= data_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_active_q <= 1'b0;
      pend_q      <= 1'b0;
    end else if (is_cm || is_ab) begin
      tx_active_q <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      if (do_alloc) tx_active_q <= 1'b1;
      if (nack_roll || cap_fail) pend_q <= 1'b1;
    end
  end

  // Slot relabelling and allocation
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        st_q[i]  <= SL_INV;
        coh_q[i] <= COH_S;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (do_roll) begin
          if (st_q[i] == SL_XCOM) st_q[i] <= SL_INV;
          if (st_q[i] == SL_XABT) st_q[i] <= SL_NORM;
        end else if (do_commit) begin
          if (st_q[i] == SL_XCOM) st_q[i] <= SL_NORM;
          if (st_q[i] == SL_XABT) st_q[i] <= SL_INV;
        end
      end
      if (tx_hit && is_st) begin
        dat_q[com_idx] <= req_wdata;
        coh_q[com_idx] <= COH_M;
        coh_q[abt_idx] <= COH_M;
      end
      if (do_alloc) begin
        for (int i = 0; i < NSLOT; i++)
          if (st_q[i] == SL_NORM && tag_q[i] == req_addr) st_q[i] <= SL_INV;
        st_q[free_lo]  <= SL_XABT;
        tag_q[free_lo] <= req_addr;
        dat_q[free_lo] <= mem_rdata;
        coh_q[free_lo] <= is_st ? COH_M : COH_S;
        st_q[free_hi]  <= SL_XCOM;
        tag_q[free_hi] <= req_addr;
        dat_q[free_hi] <= is_st ? req_wdata : mem_rdata;
        coh_q[free_hi] <= is_st ? COH_M : COH_S;
      end
    end
  end
endmodule

// File: rtl/tc_txcache_chk.sv
module tc_txcache_chk import tc_pkg::*; #(
  parameter int NSLOT = 8
) (
  input logic     clk,
  input logic     rst_n,
  input logic     req_valid,
  input logic     req_ready,
  input logic [2:0] req_op,
  input logic     rsp_valid,
  input logic     own_nack,
  input logic     snp_valid,
  input logic     snp_nack,
  input logic     tx_active_q,
  input slot_st_e st_q [NSLOT]
);
  int n_com, n_abt;
  always_comb begin
    n_com = 0;
    n_abt = 0;
    for (int i = 0; i < NSLOT; i++) begin
      if (st_q[i] == SL_XCOM) n_com++;
      if (st_q[i] == SL_XABT) n_abt++;
    end
  end

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);
  // R7
  nack_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_nack |-> snp_valid);
  // R4
  pair_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_com == n_abt);
  // R9
  line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_com <= NSLOT / 2);
  // R5
  close_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_op == OP_COMMIT || req_op == OP_ABORT)) |=> n_com == 0);
  // R8
  nack_rollback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_nack && tx_active_q) |=> n_com == 0);
endmodule

bind tc_txcache tc_txcache_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .rsp_valid(rsp_valid), .own_nack(own_nack),
  .snp_valid(snp_valid), .snp_nack(snp_nack), .tx_active_q(tx_active_q),
  .st_q(st_q));

// File: tb/sim_tc_txcache.sv
`timescale 1ns/1ps
module sim_tc_txcache;
  localparam int NSLOT = 8;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, own_nack = 1'b0, snp_valid = 1'b0, snp_write = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0, snp_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_ok, snp_nack;
  logic [DW-1:0] rsp_data;

  always #2 clk = ~clk;

  tc_txcache #(.NSLOT(NSLOT), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
    .own_nack(own_nack), .snp_valid(snp_valid), .snp_write(snp_write),
    .snp_addr(snp_addr), .snp_nack(snp_nack));

  int checks = 0, errors = 0;
  bit done = 0;

  // Arithmetic model
  int m_mem [DEPTH];
  bit m_in [DEPTH];
  int m_new [DEPTH];
  bit m_wr [DEPTH];
  int m_n = 0;
  bit m_act = 0, m_pend = 0;

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic m_drop();
    for (int a = 0; a < DEPTH; a++) begin m_in[a] = 0; m_wr[a] = 0; end
    m_n = 0;
  endtask

  task automatic do_op(input int op, input int a, input int w, input bit nk,
                       input string req);
    bit eok; int edat;
    eok = 0; edat = 0;
    if (nk && m_act && !m_pend) begin m_drop(); m_pend = 1; end
    case (op)
      0, 1: begin
        if (m_pend) eok = 0;
        else if (m_in[a]) begin
          eok = 1;
          if (op == 0) edat = m_new[a];
          else begin m_new[a] = w; m_wr[a] = 1; end
        end else if (m_n < NSLOT / 2) begin
          eok = 1; m_in[a] = 1; m_n++; m_act = 1;
          m_wr[a] = (op == 1);
          m_new[a] = (op == 1) ? w : m_mem[a];
          if (op == 0) edat = m_mem[a];
        end else begin
          eok = 0; m_drop(); m_pend = 1;
        end
      end
      2: begin
        eok = !m_pend;
        if (!m_pend)
          for (int b = 0; b < DEPTH; b++) if (m_in[b]) m_mem[b] = m_new[b];
        m_drop(); m_act = 0; m_pend = 0;
      end
      3: begin eok = 1; m_drop(); m_act = 0; m_pend = 0; end
      4: eok = !m_pend;
      default: eok = 0;
    endcase
    @(negedge clk);
    req_valid = 1; req_op = 3'(op); req_addr = AW'(a); req_wdata = DW'(w);
    own_nack = nk;
    @(negedge clk);
    req_valid = 0; own_nack = 0;
    chk(rsp_valid == 1'b1, "R1", "rsp_valid", int'(rsp_valid), 1);
    chk(rsp_ok == eok, req, $sformatf("rsp_ok op%0d addr%0d", op, a), int'(rsp_ok), int'(eok));
    chk(rsp_data == DW'(edat), req, $sformatf("rsp_data op%0d addr%0d", op, a),
        int'(rsp_data), edat);
  endtask

  task automatic do_snoop(input int a, input bit wr, input string req);
    bit exp;
    exp = m_act && !m_pend && m_in[a] && (wr || m_wr[a]);
    @(negedge clk);
    snp_valid = 1; snp_write = wr; snp_addr = AW'(a);
    #1;
    chk(snp_nack == exp, req, $sformatf("snp_nack addr%0d wr%0d", a, wr),
        int'(snp_nack), int'(exp));
    snp_valid = 0; snp_write = 0;
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      m_mem[a] = (37 * a + 5) % (1 << DW);
      m_in[a] = 0; m_wr[a] = 0; m_new[a] = 0;
    end
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R1", "req_ready in reset", int'(req_ready), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    do_snoop(3, 1, "R7");

    // R2: every backing word, one transaction per load
    for (int a = 0; a < DEPTH; a++) begin
      do_op(0, a, 0, 0, "R2");
      do_op(2, 0, 0, 0, "R5");
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid idle", int'(rsp_valid), 0);

    // R3/R4/R7/R5: stores to four lines, snoops, commit
    for (int a = 0; a < 4; a++) do_op(1, a, 200 + a, 0, "R4");
    for (int a = 0; a < 4; a++) do_op(0, a, 0, 0, "R3");
    do_op(0, 9, 0, 0, "R9");
    do_op(4, 0, 0, 0, "R10");
    do_op(3, 0, 0, 0, "R6");
    for (int a = 0; a < 4; a++) do_op(1, a, 100 + a, 0, "R3");
    do_op(0, 2, 0, 0, "R3");
    do_snoop(2, 0, "R7");
    do_snoop(9, 1, "R7");
    do_op(4, 0, 0, 0, "R10");
    do_op(2, 0, 0, 0, "R5");
    for (int a = 0; a < 4; a++) do_op(0, a, 0, 0, "R5");
    do_op(3, 0, 0, 0, "R6");

    // R7: read-only line, then R6 abort discards a store
    do_op(0, 5, 0, 0, "R2");
    do_snoop(5, 0, "R7");
    do_snoop(5, 1, "R7");
    do_op(1, 6, 77, 0, "R3");
    do_snoop(6, 0, "R7");
    do_op(3, 0, 0, 0, "R6");
    do_snoop(6, 1, "R6");
    do_op(0, 6, 0, 0, "R6");
    do_op(2, 0, 0, 0, "R5");

    // R9: capacity abort, pending behaviour
    for (int a = 10; a < 14; a++) do_op(1, a, a, 0, "R4");
    do_op(0, 14, 0, 0, "R9");
    do_op(4, 0, 0, 0, "R10");
    do_op(0, 10, 0, 0, "R10");
    do_snoop(10, 1, "R9");
    do_op(2, 0, 0, 0, "R10");
    do_op(0, 10, 0, 0, "R9");
    do_op(3, 0, 0, 0, "R6");

    // R8: own request refused
    do_op(1, 7, 55, 0, "R3");
    do_op(0, 8, 0, 1, "R8");
    do_snoop(7, 1, "R8");
    do_op(4, 0, 0, 0, "R8");
    do_op(3, 0, 0, 0, "R6");
    do_op(0, 7, 0, 0, "R8");
    do_op(3, 0, 0, 0, "R6");
    do_op(4, 0, 0, 1, "R8");

    // R11: unused operation codes
    do_op(1, 4, 9, 0, "R3");
    for (int c = 5; c < 8; c++) do_op(c, 4, 1, 0, "R11");
    do_op(0, 4, 0, 0, "R11");
    do_op(3, 0, 0, 0, "R6");

    // Pseudo-random sweep over a narrow address range
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int k = 0; k < 1500; k++) begin
        int op, a, w; bit nk; string tg;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        a = int'(lf[2:0]) % 6;
        w = int'(lf[15:8]);
        case (lf[7:4])
          0, 1, 2, 3, 4: begin op = 0; tg = "R3"; end
          5, 6, 7, 8, 9: begin op = 1; tg = "R3"; end
          10, 11: begin op = 2; tg = "R5"; end
          12: begin op = 3; tg = "R6"; end
          13, 14: begin op = 4; tg = "R10"; end
          default: begin op = 7; tg = "R11"; end
        endcase
        nk = (lf[11:8] == 4'hF);
        if (nk) tg = "R8";
        do_op(op, a, w, nk, tg);
        do_snoop(int'(lf[14:12]) % 6, lf[3], "R7");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule